// File: doc/BRIEF.md
# Fixed-Point Color Space Converter

This block converts a stream of three-component pixels from one color space to another. Each output component is a weighted sum of the three input components, using a programmable 3x3 matrix of signed coefficients. A per-channel signed offset is added, a power-of-two scale is applied, and the result is rounded and clamped. The same datapath covers RGB to YCbCr, YCbCr to RGB and a transparent RGB to RGB pass-through, depending only on the loaded constants.

Software writes the constants through a small register-write port into a shadow bank. A pixel that carries the start-of-frame flag copies the shadow bank into the working configuration, so a frame is always processed with one consistent set of constants. Pixels move through a three-stage pipeline with a valid/ready handshake on both sides. When the output is stalled, the whole pipeline freezes.

Top module: `csc_matrix`

## Requirements
- R1: After reset, out_valid_o is 0 and in_ready_o is 1. The working configuration passes pixels through unchanged: diagonal coefficients 128, all other coefficients 0, zero offsets, scale 2, saturation off.
- R2: Component k of a pixel sits at bits [8k+7:8k] of in_pix_i and out_pix_o. Output component i is floor((S + 2^(sh-1)) / 2^sh), with S = sum over j of c[i][j]*a[j] + 64*o[i] and sh = 9 - scale, then clamped. Coefficients are 9-bit two's complement integers weighted 1/256.
- R3: The 2-bit scale field multiplies the effective coefficients and offset by 2^(scale-1). Scale 0 halves them, scale 1 leaves them as they are, scale 2 doubles them and scale 3 quadruples them.
- R4: Offsets are 13-bit two's complement values in quarter units. An offset of 512 adds 128 to the output.
- R5: With saturation on, component 0 is clamped to 16..235 and components 1 and 2 are clamped to 16..240.
- R6: With saturation off, every component is clamped to 0..255 and never wraps.
- R7: A pixel accepted in cycle t is presented on the outputs in cycle t+3 when out_ready_i is high in cycles t+1 and t+2.
- R8: While out_valid_o is 1 and out_ready_i is 0, out_pix_o holds its value and in_ready_o is 0. No pixel is lost or duplicated.
- R9: The configuration write map is as follows. Addresses 0..8 hold coefficient c[i][j] at address 3i+j, in bits [8:0]. Addresses 9..11 hold offsets 0..2 in bits [12:0]. Address 12 holds the scale in bits [1:0] and the saturation enable in bit 2. Writes to addresses 13..15 have no effect.
- R10: Writes land in the shadow bank. They take effect from the next accepted pixel that has in_sof_i set, and include that pixel. Pixels accepted earlier keep the old configuration, even if they are still in the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration write address |
| cfg_wdata_i | input | 13 | Configuration write data |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Input pixel accepted when high with valid |
| in_sof_i | input | 1 | Marks the first pixel of a frame |
| in_pix_i | input | 24 | Input pixel, three 8-bit components |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream can take the output pixel |
| out_pix_o | output | 24 | Converted pixel |

## Verification
A wrong product, sum or offset register shows up as a wrong out_pix_o value three cycles after the pixel enters, so the per-cycle comparison catches it as soon as that pixel reaches the output. A stage configuration that updates at the wrong moment only becomes visible at a frame boundary. It corrupts the first pixels of the new frame, or the last pixels of the old frame that are still in flight, so the bench changes the constants in mid-stream and sends back-to-back start-of-frame pixels. A broken stall path shows up within one cycle of back-pressure, either as a changed output or as an input accepted into a frozen pipeline.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int PIX_W      = 8;
  localparam int NCH        = 3;
  localparam int NCOEF      = NCH * NCH;
  localparam int COEF_W     = 9;
  localparam int COEF_FRAC  = 8;
  localparam int OFS_W      = 13;
  localparam int OFS_FRAC   = 2;
  localparam int SCL_W      = 2;
  localparam int PROD_W     = PIX_W + COEF_W;
  localparam int ACC_W      = PROD_W + 4;
  localparam int CFG_AW     = 4;
  localparam int CFG_DW     = OFS_W;
  localparam int ADDR_OFS   = NCOEF;
  localparam int ADDR_CTRL  = NCOEF + NCH;
  localparam int IDENT_COEF = 1 << (COEF_FRAC - 1);
  localparam int IDENT_SCL  = 2;
  localparam int LEGAL_MIN  = 16;
  localparam int LUMA_MAX   = 235;
  localparam int CHROMA_MAX = 240;
  localparam int FULL_MAX   = (1 << PIX_W) - 1;

  typedef logic signed [COEF_W-1:0] coef_t;
  typedef logic signed [OFS_W-1:0]  ofs_t;
  typedef logic signed [PROD_W-1:0] prod_t;
  typedef logic signed [ACC_W-1:0]  acc_t;
  typedef logic [PIX_W-1:0]         pix_t;
  typedef struct packed {
    logic             sat;
    logic [SCL_W-1:0] scl;
  } ctrl_t;
endpackage

// File: rtl/csc_cfg_bank.sv
module csc_cfg_bank
  import csc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_AW-1:0] addr_i,
  input  logic [CFG_DW-1:0] wdata_i,
  input  logic              load_i,
  output coef_t             shd_coef_o [NCOEF],
  output ofs_t              act_ofs_o  [NCH],
  output ctrl_t             act_ctrl_o,
  output coef_t             act_coef_o [NCOEF]
);
  ofs_t  shd_ofs [NCH];
  ctrl_t shd_ctrl;

  for (genvar k = 0; k < NCOEF; k++) begin : g_coef
    localparam coef_t RST_C = (k % (NCH + 1) == 0) ? coef_t'(IDENT_COEF) : coef_t'(0);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shd_coef_o[k] <= RST_C;
        act_coef_o[k] <= RST_C;
      end else begin
        if (load_i) act_coef_o[k] <= shd_coef_o[k];
        if (we_i && addr_i == CFG_AW'(k)) shd_coef_o[k] <= wdata_i[COEF_W-1:0];
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ofs
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shd_ofs[i]   <= '0;
        act_ofs_o[i] <= '0;
      end else begin
        if (load_i) act_ofs_o[i] <= shd_ofs[i];
        if (we_i && addr_i == CFG_AW'(ADDR_OFS + i)) shd_ofs[i] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_ctrl   <= '{sat: 1'b0, scl: SCL_W'(IDENT_SCL)};
      act_ctrl_o <= '{sat: 1'b0, scl: SCL_W'(IDENT_SCL)};
    end else begin
      if (load_i) act_ctrl_o <= shd_ctrl;
      if (we_i && addr_i == CFG_AW'(ADDR_CTRL)) shd_ctrl <= wdata_i[SCL_W:0];
    end
  end
endmodule

// File: rtl/csc_mul_stage.sv
module csc_mul_stage
  import csc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  valid_i,
  input  logic  sof_i,
  input  pix_t  pix_i  [NCH],
  input  coef_t coef_i [NCOEF],
  output logic  valid_o,
  output logic  sof_o,
  output prod_t prod_o [NCOEF]
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sof_o   <= 1'b0;
    end else if (en_i) begin
      valid_o <= valid_i;
      sof_o   <= valid_i && sof_i;
    end
  end

  // product k = c[k/NCH][k%NCH] * a[k%NCH]
  for (genvar k = 0; k < NCOEF; k++) begin : g_mul
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prod_o[k] <= '0;
      else if (en_i) prod_o[k] <= prod_t'(coef_i[k]) * prod_t'($signed({1'b0, pix_i[k % NCH]}));
    end
  end
endmodule

// File: rtl/csc_sum_stage.sv
module csc_sum_stage
  import csc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  valid_i,
  input  logic  sof_i,
  input  prod_t prod_i    [NCOEF],
  input  ofs_t  cfg_ofs_i [NCH],
  input  ctrl_t cfg_ctrl_i,
  output logic  valid_o,
  output logic  sof_o,
  output acc_t  acc_o     [NCH],
  output ctrl_t ctrl_o
);
  localparam int OFS_SH = COEF_FRAC - OFS_FRAC;

  ofs_t ofs_q [NCH];
  ofs_t ofs_use [NCH];
  acc_t acc_d [NCH];
  logic take;

  assign take = valid_i && sof_i;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      ofs_use[i] = take ? cfg_ofs_i[i] : ofs_q[i];
      acc_d[i]   = acc_t'(ofs_use[i]) <<< OFS_SH;
      for (int j = 0; j < NCH; j++) acc_d[i] = acc_d[i] + acc_t'(prod_i[i*NCH + j]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sof_o   <= 1'b0;
      ctrl_o  <= '{sat: 1'b0, scl: SCL_W'(IDENT_SCL)};
      for (int i = 0; i < NCH; i++) begin
        ofs_q[i] <= '0;
        acc_o[i] <= '0;
      end
    end else if (en_i) begin
      valid_o <= valid_i;
      sof_o   <= take;
      if (take) ctrl_o <= cfg_ctrl_i;
      for (int i = 0; i < NCH; i++) begin
        if (take) ofs_q[i] <= cfg_ofs_i[i];
        acc_o[i] <= acc_d[i];
      end
    end
  end
endmodule

// File: rtl/csc_round_stage.sv
module csc_round_stage
  import csc_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  valid_i,
  input  logic  sof_i,
  input  acc_t  acc_i [NCH],
  input  ctrl_t ctrl_i,
  output logic  valid_o,
  output pix_t  pix_o [NCH]
);
  ctrl_t ctrl_q;
  ctrl_t ctrl_use;
  logic [3:0] sh;
  acc_t bias;
  acc_t rnd [NCH];
  pix_t clp [NCH];

  assign ctrl_use = (valid_i && sof_i) ? ctrl_i : ctrl_q;
  assign sh       = 4'(COEF_FRAC + 1) - 4'(ctrl_use.scl);
  assign bias     = acc_t'(1) <<< (sh - 4'd1);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      acc_t lo;
      acc_t hi;
      rnd[i] = (acc_i[i] + bias) >>> sh;
      lo = ctrl_use.sat ? acc_t'(LEGAL_MIN) : acc_t'(0);
      hi = !ctrl_use.sat ? acc_t'(FULL_MAX) : (i == 0) ? acc_t'(LUMA_MAX) : acc_t'(CHROMA_MAX);
      if (rnd[i] < lo)      clp[i] = lo[PIX_W-1:0];
      else if (rnd[i] > hi) clp[i] = hi[PIX_W-1:0];
      else                  clp[i] = rnd[i][PIX_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ctrl_q  <= '{sat: 1'b0, scl: SCL_W'(IDENT_SCL)};
      for (int i = 0; i < NCH; i++) pix_o[i] <= '0;
    end else if (en_i) begin
      valid_o <= valid_i;
      if (valid_i && sof_i) ctrl_q <= ctrl_i;
      for (int i = 0; i < NCH; i++) pix_o[i] <= clp[i];
    end
  end
endmodule

// File: rtl/csc_matrix.sv
module csc_matrix
  import csc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [CFG_AW-1:0]    cfg_addr_i,
  input  logic [CFG_DW-1:0]    cfg_wdata_i,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic                 in_sof_i,
  input  logic [NCH*PIX_W-1:0] in_pix_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic [NCH*PIX_W-1:0] out_pix_o
);
  logic  en;
  logic  load;
  coef_t shd_coef [NCOEF];
  coef_t act_coef [NCOEF];
  coef_t use_coef [NCOEF];
  ofs_t  act_ofs  [NCH];
  ctrl_t act_ctrl;
  pix_t  pix_in   [NCH];
  pix_t  pix_out  [NCH];
  logic  v1, s1, v2, s2;
  prod_t prod [NCOEF];
  acc_t  acc  [NCH];
  ctrl_t ctrl2;

  // global stall: every stage advances together
  assign en         = !out_valid_o || out_ready_i;
  assign in_ready_o = en;
  assign load       = in_valid_i && en && in_sof_i;

  for (genvar i = 0; i < NCH; i++) begin : g_pack
    assign pix_in[i]                  = in_pix_i[i*PIX_W +: PIX_W];
    assign out_pix_o[i*PIX_W +: PIX_W] = pix_out[i];
  end

  for (genvar k = 0; k < NCOEF; k++) begin : g_cuse
    assign use_coef[k] = (in_valid_i && in_sof_i) ? shd_coef[k] : act_coef[k];
  end

  csc_cfg_bank u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .addr_i     (cfg_addr_i),
    .wdata_i    (cfg_wdata_i),
    .load_i     (load),
    .shd_coef_o (shd_coef),
    .act_ofs_o  (act_ofs),
    .act_ctrl_o (act_ctrl),
    .act_coef_o (act_coef)
  );

  csc_mul_stage u_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .valid_i (in_valid_i),
    .sof_i   (in_sof_i),
    .pix_i   (pix_in),
    .coef_i  (use_coef),
    .valid_o (v1),
    .sof_o   (s1),
    .prod_o  (prod)
  );

  csc_sum_stage u_sum (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en),
    .valid_i    (v1),
    .sof_i      (s1),
    .prod_i     (prod),
    .cfg_ofs_i  (act_ofs),
    .cfg_ctrl_i (act_ctrl),
    .valid_o    (v2),
    .sof_o      (s2),
    .acc_o      (acc),
    .ctrl_o     (ctrl2)
  );

  csc_round_stage u_rnd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .valid_i (v2),
    .sof_i   (s2),
    .acc_i   (acc),
    .ctrl_i  (ctrl2),
    .valid_o (out_valid_o),
    .pix_o   (pix_out)
  );
endmodule

// File: rtl/csc_matrix_chk.sv
module csc_matrix_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_valid_i,
  input logic        in_ready_o,
  input logic        out_valid_o,
  input logic        out_ready_i,
  input logic [23:0] out_pix_o
);
  logic [2:0] occ;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ <= '0;
    else occ <= occ + 3'(in_valid_i && in_ready_o) - 3'(out_valid_o && out_ready_i);
  end

  a_r8_hold_pix: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_pix_o));

  a_r8_no_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  a_r7_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) ##1 out_ready_i ##1 out_ready_i |=> out_valid_o);

  a_r8_no_phantom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> occ != 3'd0);

  a_r8_occ_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ <= 3'd3);
endmodule

bind csc_matrix csc_matrix_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_pix_o   (out_pix_o)
);

// File: tb/csc_matrix_tb.sv
module csc_matrix_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_addr_i = '0;
  logic [12:0] cfg_wdata_i = '0;
  logic        in_valid_i = 1'b0;
  logic        in_ready_o;
  logic        in_sof_i = 1'b0;
  logic [23:0] in_pix_i = '0;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic [23:0] out_pix_o;

  int n_chk = 0;
  int n_err = 0;
  string cur_req = "R1";

  int sh_c [9];
  int sh_o [3];
  int sh_s, sh_sat;
  int ac_c [9];
  int ac_o [3];
  int ac_s, ac_sat;
  logic [23:0] q_px [$];
  int          q_st [$];

  always #10 clk_i = ~clk_i;

  csc_matrix u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i), .in_valid_i(in_valid_i), .in_ready_o(in_ready_o),
    .in_sof_i(in_sof_i), .in_pix_i(in_pix_i), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .out_pix_o(out_pix_o)
  );

  function automatic logic [23:0] ref_px(input logic [23:0] p);
    logic [23:0] r;
    for (int i = 0; i < 3; i++) begin
      int acc, sh, v, lo, hi;
      acc = ac_o[i] * 64;
      for (int j = 0; j < 3; j++) acc += ac_c[i*3+j] * int'(p[j*8 +: 8]);
      sh = 9 - ac_s;
      v = (acc + (1 << (sh - 1))) >>> sh;
      lo = ac_sat ? 16 : 0;
      hi = ac_sat ? ((i == 0) ? 235 : 240) : 255;
      if (v < lo) v = lo;
      if (v > hi) v = hi;
      r[i*8 +: 8] = 8'(v);
    end
    return r;
  endfunction

  task automatic cyc(input logic v, input logic sof, input logic [23:0] pix, input logic rdy,
                     input logic we, input logic [3:0] addr, input logic [12:0] wd);
    logic exp_v, en_m;
    in_valid_i = v; in_sof_i = sof; in_pix_i = pix; out_ready_i = rdy;
    cfg_we_i = we; cfg_addr_i = addr; cfg_wdata_i = wd;
    #1;
    exp_v = (q_px.size() > 0) && (q_st[0] == 2);
    en_m = !(exp_v && !rdy);
    n_chk++;
    if (out_valid_o !== exp_v || (exp_v && out_pix_o !== q_px[0]) || in_ready_o !== en_m) begin
      n_err++;
      $display("FAIL %s: valid=%0b pix=%h ready=%0b expected valid=%0b pix=%h ready=%0b",
               cur_req, out_valid_o, out_pix_o, in_ready_o, exp_v,
               exp_v ? q_px[0] : 24'h0, en_m);
    end
    if (en_m) begin
      if (exp_v) begin void'(q_px.pop_front()); void'(q_st.pop_front()); end
      foreach (q_st[k]) q_st[k]++;
      if (v) begin
        if (sof) begin ac_c = sh_c; ac_o = sh_o; ac_s = sh_s; ac_sat = sh_sat; end
        q_px.push_back(ref_px(pix));
        q_st.push_back(0);
      end
    end
    if (we) begin
      if (addr < 9) sh_c[addr] = int'($signed(wd[8:0]));
      else if (addr < 12) sh_o[addr-9] = int'($signed(wd));
      else if (addr == 12) begin sh_s = int'(wd[1:0]); sh_sat = int'(wd[2]); end
    end
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [3:0] a, input int d);
    cyc(1'b0, 1'b0, 24'h0, 1'b1, 1'b1, a, 13'(d));
  endtask

  task automatic px(input logic sof, input logic [23:0] p);
    cyc(1'b1, sof, p, 1'b1, 1'b0, 4'd0, 13'd0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 24'h0, 1'b1, 1'b0, 4'd0, 13'd0);
  endtask

  task automatic prog(input int c0, c1, c2, c3, c4, c5, c6, c7, c8,
                      input int o0, o1, o2, input int scl, input int sat);
    wr(0, c0); wr(1, c1); wr(2, c2); wr(3, c3); wr(4, c4);
    wr(5, c5); wr(6, c6); wr(7, c7); wr(8, c8);
    wr(9, o0); wr(10, o1); wr(11, o2); wr(12, sat * 4 + scl);
  endtask

  initial begin
    for (int k = 0; k < 9; k++) sh_c[k] = (k % 4 == 0) ? 128 : 0;
    for (int i = 0; i < 3; i++) sh_o[i] = 0;
    sh_s = 2; sh_sat = 0;
    ac_c = sh_c; ac_o = sh_o; ac_s = sh_s; ac_sat = sh_sat;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    cur_req = "R1";
    n_chk++;
    if (out_valid_o !== 1'b0 || in_ready_o !== 1'b1) begin
      n_err++;
      $display("FAIL R1: valid=%0b ready=%0b expected valid=0 ready=1", out_valid_o, in_ready_o);
    end
    px(1'b1, 24'h123456); px(1'b0, 24'hFF00A5); px(1'b0, 24'h000000); px(1'b0, 24'hFFFFFF);
    idle(4);

    cur_req = "R7";
    px(1'b0, 24'h5A5A5A); idle(4);

    cur_req = "R2";
    prog(77, 150, 29, -43, -85, 128, 128, -107, -21, 0, 512, 512, 1, 0);
    px(1'b1, 24'hFFFFFF); px(1'b0, 24'h000000); px(1'b0, 24'h0000FF);
    px(1'b0, 24'h00FF00); px(1'b0, 24'hFF0000);
    cur_req = "R4";
    for (int i = 0; i < 8; i++) px(1'b0, 24'($urandom));
    idle(4);

    cur_req = "R5";
    prog(149, 0, 204, 149, -50, -104, 149, 255, 0, -446, 266, -554, 2, 1);
    px(1'b1, 24'h000000); px(1'b0, 24'hFFFFFF); px(1'b0, 24'h808080);
    px(1'b0, 24'hFF00FF); px(1'b0, 24'h00FF00);
    for (int i = 0; i < 6; i++) px(1'b0, 24'($urandom));
    idle(4);

    cur_req = "R6";
    wr(12, 2);
    px(1'b1, 24'h000000); px(1'b0, 24'hFFFFFF); px(1'b0, 24'hFF00FF); px(1'b0, 24'h00FF00);
    idle(4);

    cur_req = "R3";
    prog(100, 20, -30, -60, 90, 15, 7, -8, 200, 40, -40, 300, 0, 0);
    px(1'b1, 24'h80FF10);
    for (int i = 0; i < 5; i++) px(1'b0, 24'($urandom));
    wr(12, 3);
    px(1'b1, 24'h102030);
    for (int i = 0; i < 5; i++) px(1'b0, 24'($urandom));
    wr(12, 1);
    px(1'b1, 24'h7F7F7F);
    idle(4);

    cur_req = "R9";
    wr(13, 13'h1FFF); wr(14, 13'h0ABC); wr(15, 13'h1234);
    px(1'b1, 24'h4488CC); px(1'b0, 24'hC08040);
    wr(4, -128);
    px(1'b1, 24'h4488CC);
    idle(4);

    cur_req = "R10";
    px(1'b1, 24'h102030); px(1'b0, 24'h405060);
    cyc(1'b1, 1'b0, 24'h708090, 1'b1, 1'b1, 4'd0, 13'd255);
    cyc(1'b1, 1'b0, 24'hA0B0C0, 1'b1, 1'b1, 4'd9, 13'h1F00);
    px(1'b0, 24'hD0E0F0);
    px(1'b1, 24'h112233); px(1'b1, 24'h445566);
    cyc(1'b1, 1'b1, 24'h778899, 1'b1, 1'b1, 4'd12, 13'd6);
    px(1'b1, 24'hAABBCC); px(1'b0, 24'hDDEEFF);
    idle(4);

    cur_req = "R8";
    for (int i = 0; i < 80; i++) begin
      logic v, s, r;
      v = 1'($urandom); s = (($urandom % 8) == 0); r = 1'($urandom);
      cyc(v, s, 24'($urandom), r, 1'b0, 4'd0, 13'd0);
    end
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 24'h0, 1'b0, 1'b0, 4'd0, 13'd0);
    idle(5);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++;
    n_err++;
    $display("FAIL %s: watchdog expired, actual=hung expected=done", cur_req);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule